// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the read side of a byte-wide non-volatile memory and decides what the data bus carries during a read. While the programming controller reports an internal programming cycle in progress, an ordinary read does not return stored data. It returns two status indications instead. Bit 7 carries the inverse of bit 7 of the byte most recently written. Bit 6 changes state on every new read access. Bits 5 to 0 carry the matching bits of that last written byte. Once the programming cycle ends, reads return the array contents again. A host can therefore find out that programming has finished by polling either bit.

The bus is driven only while both active-low enables, chip enable and output enable, are low. A write attempt that the protection logic rejects produces no status indication: reads keep returning array contents until the next accepted programming cycle starts. The enables and the busy flag are synchronous inputs, sampled on the block clock. The start of a read access is the first clock at which both enables are seen low after a clock at which they were not.

Top module: `wcs_status_reporter`

## Requirements
- R1: `dq_oe` is 1 exactly when `ce_n` and `oe_n` are both 0, in the same cycle. While `dq_oe` is 0, `dq_out` is all zeros.
- R2: While `busy` is 0, an enabled read returns `arr_data` unchanged on `dq_out`.
- R3: While status is active (`busy` is 1 and no rejection is recorded), an enabled read returns the complement of `last_data[7]` on `dq_out[7]`.
- R4: While status is active, `dq_out[5:0]` equals `last_data[5:0]` on an enabled read.
- R5: On the first read access after `busy` rises, `dq_out[6]` is 1. Each later access in the same busy period presents the inverse of the value seen on the previous access.
- R6: `dq_out[6]` stays constant while one access is held (enables kept low across several clocks). Only a new access, with the enables going high and then low again, advances it.
- R7: A one-cycle `prot_rej` pulse suppresses status. From the next clock, reads return `arr_data` even though `busy` is 1, until `busy` falls and rises again.
- R8: Each new rise of `busy` restarts the bit-6 sequence, so its first access shows 1 whatever value the previous busy period ended on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Programming cycle in progress, from the programming controller |
| prot_rej | input | 1 | One-cycle pulse: a write attempt was refused by protection |
| last_data | input | 8 | Byte most recently accepted for programming |
| arr_data | input | 8 | Array contents at the current read address |
| dq_out | output | 8 | Data value presented on the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The hardest situation to reach is a bit-6 sequence that crosses a busy boundary with the toggle left at 0. The stimulus reaches it by varying the number of reads in each busy period between two and three, so that periods end on both toggle values. It also has to keep the enables high across at least one clock edge between accesses, because otherwise no new access is seen. The held-access case is reached by keeping both enables low over several clocks. The rejection case is reached by pulsing `prot_rej` inside a busy period and then lowering and raising `busy` again.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    // State of the access detector
    typedef struct packed {
        logic strb;
    } strobe_st_t;

    // State of the status tracker
    typedef struct packed {
        logic busy;
        logic rej;
        logic tog;
    } track_st_t;

    localparam strobe_st_t STROBE_RST = '{strb: 1'b0};
    localparam track_st_t  TRACK_RST  = '{busy: 1'b0, rej: 1'b0, tog: 1'b0};

endpackage

// File: rtl/wcs_strobe.sv
module wcs_strobe
    import wcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic strobe,
    output logic start
);

    strobe_st_t st_d, st_q;

    always_comb begin
        strobe  = ~ce_n & ~oe_n;
        start   = strobe & ~st_q.strb;
        st_d    = st_q;
        st_d.strb = strobe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STROBE_RST;
        else        st_q <= st_d;
    end

    // R6
    start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

endmodule

// File: rtl/wcs_status_track.sv
module wcs_status_track
    import wcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic prot_rej,
    input  logic strobe,
    input  logic start,
    output logic status,
    output logic tog_bit
);

    track_st_t st_d, st_q;
    logic      busy_rise;
    logic      tog_base;

    always_comb begin
        busy_rise = busy & ~st_q.busy;
        status    = busy & ~st_q.rej;
        tog_base  = busy_rise ? 1'b0 : st_q.tog;
        tog_bit   = tog_base ^ (start & status);

        st_d      = st_q;
        st_d.busy = busy;
        if (prot_rej)       st_d.rej = 1'b1;
        else if (busy_rise) st_d.rej = 1'b0;
        st_d.tog  = status ? tog_bit : tog_base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TRACK_RST;
        else        st_q <= st_d;
    end

    // R6
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !start && status && $past(status) && !busy_rise) |-> $stable(tog_bit));

    // R7
    rej_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_rej && busy) |=> (!status || $rose(busy)));

endmodule

// File: rtl/wcs_bus_mux.sv
module wcs_bus_mux #(
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic              strobe,
    input  logic              status,
    input  logic              tog_bit,
    input  logic [DATA_W-1:0] last_data,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic [DATA_W-1:0] stat_word;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == POLL_BIT) begin : g_poll
            assign stat_word[i] = ~last_data[i];
        end else if (i == TOG_BIT) begin : g_tog
            assign stat_word[i] = tog_bit;
        end else begin : g_pass
            assign stat_word[i] = last_data[i];
        end
    end

    always_comb begin
        dq_oe = strobe;
        if (!strobe)     dq_out = '0;
        else if (status) dq_out = stat_word;
        else             dq_out = arr_data;
    end

endmodule

// File: rtl/wcs_status_reporter.sv
module wcs_status_reporter #(
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              busy,
    input  logic              prot_rej,
    input  logic [DATA_W-1:0] last_data,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    localparam int LOW_W = (TOG_BIT < POLL_BIT) ? TOG_BIT : POLL_BIT;

    logic strobe, start, status, tog_bit;

    wcs_strobe u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .strobe (strobe),
        .start  (start)
    );

    wcs_status_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .prot_rej (prot_rej),
        .strobe   (strobe),
        .start    (start),
        .status   (status),
        .tog_bit  (tog_bit)
    );

    wcs_bus_mux #(
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT)
    ) u_mux (
        .strobe    (strobe),
        .status    (status),
        .tog_bit   (tog_bit),
        .last_data (last_data),
        .arr_data  (arr_data),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    // R1
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (!dq_oe && dq_out == '0));

    // R2
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && dq_oe) |-> dq_out == arr_data);

    // R3
    poll_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && status) |-> dq_out[POLL_BIT] != last_data[POLL_BIT]);

    // R4
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && status) |-> dq_out[LOW_W-1:0] == last_data[LOW_W-1:0]);

endmodule

// File: tb/wcs_status_reporter_test.sv
module wcs_status_reporter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1, busy = 1'b0, prot_rej = 1'b0;
    logic [7:0] last_data = '0, arr_data = '0;
    logic [7:0] dq_out;
    logic       dq_oe;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    wcs_status_reporter uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
        .prot_rej(prot_rej), .last_data(last_data), .arr_data(arr_data),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one access: enables low for one clock, then high across a clock edge
    task automatic rd(output logic [7:0] v, output logic e);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        #1; v = dq_out; e = dq_oe;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        logic       e;
        logic [7:0] exp;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state: bus quiet
        chk("R1 reset", {dq_oe, dq_out}, 9'h000);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 all enable combinations
        arr_data = 8'hA5;
        for (int c = 0; c < 4; c++) begin
            ce_n = c[0]; oe_n = c[1];
            #1;
            chk("R1 enables", {dq_oe, dq_out}, (c == 0) ? {1'b1, 8'hA5} : 9'h000);
            @(negedge clk);
        end
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);

        // R2 idle reads, full sweep
        for (int a = 0; a < 256; a++) begin
            arr_data  = a[7:0];
            last_data = 8'(a * 7 + 3);
            rd(v, e);
            chk("R2 idle read", {e, v}, {1'b1, a[7:0]});
        end

        // R3 R4 R5 R8 sweep over every last written byte
        for (int d = 0; d < 256; d++) begin
            last_data = d[7:0];
            arr_data  = ~d[7:0];
            busy = 1'b1;
            @(negedge clk);
            for (int k = 1; k <= 2 + (d % 2); k++) begin
                exp = {~d[7], k[0], d[5:0]};
                rd(v, e);
                chk((k == 1) ? "R8 first access after busy rise" : "R3/R4/R5 status read",
                    {e, v}, {1'b1, exp});
            end
            busy = 1'b0;
            @(negedge clk);
            rd(v, e);
            chk("R2 true data after busy", {e, v}, {1'b1, ~d[7:0]});
        end

        // R6 held access keeps bit 6, next access flips
        last_data = 8'h3C;
        busy = 1'b1;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        for (int h = 0; h < 4; h++) begin
            #1;
            chk("R6 held access", {dq_oe, dq_out}, {1'b1, 8'hC0 | 8'h7C});
            @(negedge clk);
        end
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        rd(v, e);
        chk("R6 new access flips", {e, v}, {1'b1, 8'hBC});
        rd(v, e);
        chk("R5 third access", {e, v}, {1'b1, 8'hFC});

        // R7 rejected write suppresses status
        arr_data = 8'h5A;
        @(negedge clk); prot_rej = 1'b1;
        @(negedge clk); prot_rej = 1'b0;
        for (int r = 0; r < 3; r++) begin
            rd(v, e);
            chk("R7 rejected write reads array", {e, v}, {1'b1, 8'h5A});
        end
        busy = 1'b0;
        @(negedge clk);
        busy = 1'b1;
        @(negedge clk);
        rd(v, e);
        chk("R7 status back on new busy", {e, v}, {1'b1, 8'hFC});

        busy = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule